// File: doc/BRIEF.md
# Fractional M/N Clock Divider

This block turns one of four parent clock sources into a slower divided clock whose average frequency is the parent rate multiplied by M and divided by N. M is a 9-bit value and N is a 20-bit value. Because N is never allowed below 2*M, the divided clock can run no faster than half the parent rate. All logic runs on one system clock. Each parent source is presented as a one-cycle tick strobe on `src_tick`, so switching between parents is a plain multiplexer of strobes and needs no analog or glitch-free clock switching.

A single 32-bit control word holds the parent select, a run bit, M and N. It is written through a plain write strobe and can always be read back. Each tick of the selected parent adds 2*M to a phase accumulator. When the sum reaches N, N is subtracted and `div_clk` toggles, which gives the rate M/N on average. `div_rise` marks every rising edge of `div_clk` for logic that wants an enable instead of a level.

There is no data stream here, so the block has no valid/ready handshake. Every pin is a plain control or status signal, and a write is accepted or rejected in the cycle it is presented.

Top module: `mn_frac_div`

## Requirements
- R1: After reset the control word reads 0, `cfg_err` is 0, `div_clk` is low and `div_rise` is 0.
- R2: Control word layout: bits 31:30 are the parent select, bit 29 is the run bit, bits 28:20 are M and bits 19:0 are N. `rd_data` always returns the last accepted word.
- R3: A write is accepted only when M >= 1 and N >= 2*M, so the boundary N = 2*M is legal. Any other write leaves the whole control word unchanged and sets `cfg_err`.
- R4: `cfg_err` is sticky. Later legal writes do not clear it, and only reset does.
- R5: When an accepted write clears the run bit, `div_clk` is low from the next clock on, and `div_rise` stays 0 while the run bit is clear.
- R6: When an accepted write sets the run bit, the cycle after the write loads the configuration. From then on, after k ticks of the selected parent, `div_clk` equals floor(2*M*k/N) mod 2.
- R7: `div_rise` is high for exactly one cycle: the cycle in which `div_clk` has just gone from 0 to 1.
- R8: Only ticks on `src_tick[sel]` advance the divider. Ticks on the other sources have no effect.
- R9: A change of M, N or parent select made while running is held back until the next high-to-low transition of `div_clk`. At that point the accumulator restarts from zero with the new values. If the values have not changed, the accumulator keeps its remainder.
- R10: Over a run of K ticks from start, the number of `div_rise` pulses equals ceil(floor(2*M*K/N)/2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | One tick strobe per parent source |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Current control word |
| cfg_err | output | 1 | Sticky flag for a rejected write |
| div_clk | output | 1 | Divided clock level |
| div_rise | output | 1 | One-cycle pulse on each rising edge of div_clk |

## Verification
Assertions check several properties on every cycle. The accumulator stays below the active N. A cleared run bit forces the output low with no rise pulse. The active configuration only changes when the output is low. A rise pulse always matches a 0-to-1 output step. A rejected write leaves the word frozen and raises the error flag, and that flag never falls. The bench scenarios cover what the assertions cannot: the exact phase of `div_clk` tick by tick across a sweep of small M/N pairs, the long-run pulse count, the deferral of a reconfiguration to the next falling edge, and the isolation of the unselected parents.

// File: rtl/mn_div_pkg.sv
package mn_div_pkg;
  // legal divide ratio: multiplier non-zero, divisor at least twice it
  function automatic logic ratio_legal(input int unsigned m, input int unsigned n);
    return (m != 0) && (n >= 2 * m);
  endfunction
endpackage

// File: rtl/mn_div_regs.sv
module mn_div_regs #(
  parameter int M_W   = 9,
  parameter int N_W   = 20,
  parameter int SEL_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SEL_W+M_W+N_W:0]       wr_data,
  output logic [SEL_W+M_W+N_W:0]       word_q,
  output logic                         err_q,
  output logic [SEL_W-1:0]             cfg_sel,
  output logic                         cfg_run,
  output logic [M_W-1:0]               cfg_m,
  output logic [N_W-1:0]               cfg_n
);
  localparam int WORD_W  = SEL_W + M_W + N_W + 1;
  localparam int M_LSB   = N_W;
  localparam int RUN_BIT = N_W + M_W;
  localparam int SEL_LSB = RUN_BIT + 1;

  logic [M_W-1:0] new_m;
  logic [N_W-1:0] new_n;
  logic           new_ok;

  assign new_m  = wr_data[M_LSB +: M_W];
  assign new_n  = wr_data[0 +: N_W];
  assign new_ok = mn_div_pkg::ratio_legal(32'(new_m), 32'(new_n));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      err_q  <= 1'b0;
    end else if (wr_en) begin
      if (new_ok) word_q <= wr_data;
      else        err_q  <= 1'b1;
    end
  end

  assign cfg_sel = word_q[SEL_LSB +: SEL_W];
  assign cfg_run = word_q[RUN_BIT];
  assign cfg_m   = word_q[M_LSB +: M_W];
  assign cfg_n   = word_q[0 +: N_W];

  // R3: illegal ratio freezes the word and raises the flag
  assert_reject_freezes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ((new_m == '0) ||
              ({1'b0, new_n} < {{(N_W-M_W){1'b0}}, new_m, 1'b0}))
    |=> $stable(word_q) && err_q);

  // R4: error flag never drops outside reset
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  logic unused_w;
  assign unused_w = ^WORD_W;
endmodule

// File: rtl/mn_div_src_mux.sv
module mn_div_src_mux #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   sel,
  output logic               tick
);
  logic [NUM_SRC-1:0] hits;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hits[g] = src_tick[g] && (sel == SEL_W'(g));
  end

  assign tick = |hits;
endmodule

// File: rtl/mn_div_engine.sv
module mn_div_engine #(
  parameter int M_W   = 9,
  parameter int N_W   = 20,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [M_W-1:0]   cfg_m,
  input  logic [N_W-1:0]   cfg_n,
  input  logic             tick,
  output logic [SEL_W-1:0] act_sel,
  output logic             level_q,
  output logic             rise_q
);
  localparam int ACC_W = N_W + 1;

  logic [M_W-1:0]   act_m;
  logic [N_W-1:0]   act_n;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] sum;
  logic             wrap;
  logic             pending;
  logic             live_q;

  always_comb begin
    step    = {{(ACC_W-M_W-1){1'b0}}, act_m, 1'b0};
    sum     = acc_q + step;
    wrap    = sum >= {1'b0, act_n};
    pending = (cfg_sel != act_sel) || (cfg_m != act_m) || (cfg_n != act_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      level_q <= 1'b0;
      rise_q  <= 1'b0;
      live_q  <= 1'b0;
      act_sel <= '0;
      act_m   <= '0;
      act_n   <= '0;
    end else begin
      rise_q <= 1'b0;
      if (!run) begin
        live_q  <= 1'b0;
        acc_q   <= '0;
        level_q <= 1'b0;
      end else if (!live_q) begin
        live_q  <= 1'b1;
        acc_q   <= '0;
        act_sel <= cfg_sel;
        act_m   <= cfg_m;
        act_n   <= cfg_n;
      end else if (tick) begin
        if (wrap) begin
          level_q <= ~level_q;
          rise_q  <= ~level_q;
          if (level_q && pending) begin
            acc_q   <= '0;
            act_sel <= cfg_sel;
            act_m   <= cfg_m;
            act_n   <= cfg_n;
          end else begin
            acc_q <= sum - {1'b0, act_n};
          end
        end else begin
          acc_q <= sum;
        end
      end
    end
  end

  // R6: phase stays below the active divisor while running
  assert_acc_below_n_R6: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> acc_q < {1'b0, act_n});

  // R5: stopped divider drives low with no pulse
  assert_stop_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !level_q && !rise_q);

  // R9: active setting only moves while the output is low
  assert_cfg_swap_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({act_sel, act_m, act_n}) |-> !level_q);

  // R7: pulse coincides with a 0-to-1 output step
  assert_rise_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> level_q && !$past(level_q));
endmodule

// File: rtl/mn_frac_div.sv
module mn_frac_div #(
  parameter int NUM_SRC = 4,
  parameter int M_W     = 9,
  parameter int N_W     = 20,
  parameter int SEL_W   = $clog2(NUM_SRC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SRC-1:0]     src_tick,
  input  logic                   wr_en,
  input  logic [SEL_W+M_W+N_W:0] wr_data,
  output logic [SEL_W+M_W+N_W:0] rd_data,
  output logic                   cfg_err,
  output logic                   div_clk,
  output logic                   div_rise
);
  logic [SEL_W-1:0] cfg_sel;
  logic             cfg_run;
  logic [M_W-1:0]   cfg_m;
  logic [N_W-1:0]   cfg_n;
  logic [SEL_W-1:0] act_sel;
  logic             tick;

  mn_div_regs #(.M_W(M_W), .N_W(N_W), .SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .word_q  (rd_data),
    .err_q   (cfg_err),
    .cfg_sel (cfg_sel),
    .cfg_run (cfg_run),
    .cfg_m   (cfg_m),
    .cfg_n   (cfg_n)
  );

  mn_div_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .src_tick (src_tick),
    .sel      (act_sel),
    .tick     (tick)
  );

  mn_div_engine #(.M_W(M_W), .N_W(N_W), .SEL_W(SEL_W)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (cfg_run),
    .cfg_sel (cfg_sel),
    .cfg_m   (cfg_m),
    .cfg_n   (cfg_n),
    .tick    (tick),
    .act_sel (act_sel),
    .level_q (div_clk),
    .rise_q  (div_rise)
  );
endmodule

// File: tb/test_mn_frac_div.sv
module test_mn_frac_div;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        cfg_err;
  logic        div_clk;
  logic        div_rise;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mn_frac_div i_mn_frac_div (
    .clk (clk), .rst_n (rst_n), .src_tick (src_tick),
    .wr_en (wr_en), .wr_data (wr_data), .rd_data (rd_data),
    .cfg_err (cfg_err), .div_clk (div_clk), .div_rise (div_rise)
  );

  function automatic logic [31:0] mk(int sel, int run, int m, int n);
    return (32'(sel) << 30) | (32'(run) << 29) | (32'(m) << 20) | 32'(n);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // start from a stopped state, then run K ticks on parent 0
  task automatic run_cfg(input int m, input int n, input int k_max);
    int bad = 0, rises = 0, t = 0;
    bit prev = 0;
    src_tick = 4'b1111;
    wr(mk(0, 0, 1, 2));
    wr(mk(0, 1, m, n));
    @(posedge clk);
    for (int k = 1; k <= k_max; k++) begin
      bit e, er;
      @(posedge clk);
      @(negedge clk);
      t  = (2 * m * k) / n;
      e  = t[0];
      er = e && !prev;
      if (div_clk !== e) bad++;
      if (div_rise !== er) bad++;
      rises += int'(div_rise);
      prev = e;
    end
    chk(bad == 0, $sformatf("R6/R7 phase m=%0d n=%0d", m, n), bad, 0);
    chk(rises == (t + 1) / 2, $sformatf("R10 count m=%0d n=%0d", m, n), rises, (t + 1) / 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    int highs, nt, t;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(rd_data == 0, "R1 word", rd_data, 0);
    chk(cfg_err == 0, "R1 err", cfg_err, 0);
    chk(div_clk == 0 && div_rise == 0, "R1 out", {div_clk, div_rise}, 0);

    // R2 / R3 boundary N = 2M accepted with exact layout
    wr(mk(3, 0, 511, 1022));
    chk(rd_data == 32'hDFF003FE, "R2 layout", rd_data, 32'hDFF003FE);
    chk(cfg_err == 0, "R3 boundary legal", cfg_err, 0);

    // R6/R7/R10 near-exhaustive sweep of small ratios
    for (int m = 1; m <= 4; m++)
      for (int n = 2 * m; n <= 2 * m + 7; n++)
        run_cfg(m, n, 2 * n + 5);
    run_cfg(100, 777, 1000);
    run_cfg(511, 1022, 40);
    chk(cfg_err == 0, "R3 no error on legal", cfg_err, 0);

    // R9 deferred reconfiguration
    src_tick = 4'b1111;
    wr(mk(0, 0, 1, 2));
    wr(mk(0, 1, 1, 8));
    @(posedge clk);
    for (int k = 1; k <= 5; k++) begin @(posedge clk); @(negedge clk); end
    chk(div_clk == 1, "R9 pre high", div_clk, 1);
    wr_en = 1'b1; wr_data = mk(0, 1, 1, 2);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    chk(div_clk == 1, "R9 k6 old ratio", div_clk, 1);
    for (int k = 7; k <= 11; k++) begin
      int e;
      @(posedge clk); @(negedge clk);
      e = (k <= 8) ? ((2 * k) / 8) % 2 : (k - 8) % 2;
      chk(div_clk == e[0], $sformatf("R9 k=%0d", k), div_clk, e);
    end

    // R5 stop
    wr(mk(0, 0, 1, 2));
    @(posedge clk); @(negedge clk);
    chk(div_clk == 0, "R5 low after stop", div_clk, 0);
    highs = 0;
    for (int c = 0; c < 8; c++) begin
      @(posedge clk); @(negedge clk);
      highs += int'(div_clk) + int'(div_rise);
    end
    chk(highs == 0, "R5 quiet while stopped", highs, 0);

    // R8 parent select: parent 1 selected, only parent 0 ticks
    src_tick = 4'b0001;
    wr(mk(1, 1, 1, 2));
    @(posedge clk);
    highs = 0;
    for (int c = 0; c < 10; c++) begin
      @(posedge clk); @(negedge clk);
      highs += int'(div_clk) + int'(div_rise);
    end
    chk(highs == 0, "R8 other parent ignored", highs, 0);
    src_tick = 4'b0010;
    @(posedge clk); @(negedge clk);
    chk(div_clk == 1, "R8 selected parent ticks", div_clk, 1);

    // R8 sparse ticks on parent 2
    src_tick = 4'b0000;
    wr(mk(2, 0, 1, 3));
    wr(mk(2, 1, 1, 3));
    @(posedge clk);
    nt = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      src_tick = (c % 3 == 0) ? 4'b0101 : 4'b1010;
      if (c % 3 == 0) nt++;
      @(posedge clk);
    end
    @(negedge clk);
    src_tick = 4'b0000;
    t = (2 * nt) / 3;
    chk(div_clk == t[0], "R8 sparse parent phase", div_clk, t % 2);

    // R3 / R4 rejection and stickiness
    keep = rd_data;
    wr(mk(0, 1, 3, 5));
    chk(rd_data == keep, "R3 N<2M rejected", rd_data, keep);
    chk(cfg_err == 1, "R3 flag set", cfg_err, 1);
    wr(mk(1, 0, 0, 9));
    chk(rd_data == keep, "R3 M=0 rejected", rd_data, keep);
    wr(mk(0, 1, 1, 4));
    chk(rd_data == mk(0, 1, 1, 4), "R3 legal after error", rd_data, mk(0, 1, 1, 4));
    chk(cfg_err == 1, "R4 flag sticky", cfg_err, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule